// File: doc/BRIEF.md
# USB Link Power Management Attribute Unit

This block keeps the attribute word of a USB Link Power Management (LPM) exchange and acts on it. In device mode the decoded fields of each received LPM token are copied into the word when the handshake returned for that token is ACK and the requested link state is the sleep state L1. A one-cycle accept pulse marks such a token. A token that asks for any other link state produces a one-cycle reject pulse and does not touch the word. In host mode the word holds whatever software wrote, and it forms the payload of the next outgoing LPM token. Hardware leaves it alone in that mode.

Software reads and writes the word over a simple register port. Writes are blocked while the write-protect input is high. The block also turns the resume-duration code into a timed resume-drive window, counted in 1 µs ticks. It also manages the temporary remote-wake enable. The captured enable is seen only while a suspend is in progress. It is cleared when that suspend ends, and the wake capability negotiated at enumeration then applies again.

Top module: `lpm_attr_unit`

## Requirements
- R1: After reset the attribute word reads 0x0000, and lpm_accept, lpm_reject, resume_drive, resume_done and wake_effective are all low.
- R2: The word layout is fixed. The endpoint is in bits 15:12, the remote-wake enable in bit 8, the resume-duration code in bits 7:4 and the link state in bits 3:0. Bits 11:9 always read 0, whatever is written to them.
- R3: A software write with write_protect low replaces the word on the next clock. A write with write_protect high leaves the word unchanged.
- R4: In device mode (host_mode=0), a token with tok_valid=1, tok_ack=1 and link state 1 loads its four fields into the word on the next clock. lpm_accept is high for exactly that one cycle.
- R5: A device-mode token with link state 1 whose handshake is not ACK (tok_ack=0) leaves the word unchanged and raises neither pulse.
- R6: A device-mode token with any link state other than 1 raises lpm_reject for one cycle, whatever its handshake. It leaves the word unchanged and does not raise lpm_accept.
- R7: In host mode (host_mode=1), received tokens are ignored. The word keeps the value software wrote, and neither pulse is raised.
- R8: When a software write and an accepted capture occur in the same cycle, the word takes the captured fields.
- R9: A start_resume strobe loads a counter with 50 + 75 × (bits 7:4 of the word). resume_drive then stays high for exactly that many us_tick pulses. resume_done is high for the single cycle after the last tick, when resume_drive falls.
- R10: wake_effective is registered. It follows bit 8 of the word while suspend_active is high, and it follows enum_wake_cap while suspend_active is low.
- R11: When suspend_active falls, bit 8 of the word is cleared, unless a capture happens on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 selects host mode, 0 selects device mode |
| write_protect | input | 1 | Blocks software writes while high |
| reg_wr_en | input | 1 | Software write strobe |
| reg_wr_data | input | 16 | Software write data |
| reg_rd_data | output | 16 | Current attribute word |
| tok_valid | input | 1 | A decoded LPM token is present this cycle |
| tok_ack | input | 1 | The handshake for that token is ACK |
| tok_endpoint | input | 4 | Endpoint field of the token |
| tok_rmtwak | input | 1 | Remote-wake enable field of the token |
| tok_hird | input | 4 | Resume-duration code of the token |
| tok_lnkstate | input | 4 | Requested link state of the token |
| lpm_accept | output | 1 | One-cycle pulse for an accepted L1 token |
| lpm_reject | output | 1 | One-cycle pulse for a token with a reserved link state |
| us_tick | input | 1 | One pulse per microsecond |
| start_resume | input | 1 | Starts the resume-drive window |
| resume_drive | output | 1 | High while resume is being driven |
| resume_done | output | 1 | One-cycle pulse when the window ends |
| suspend_active | input | 1 | A suspend cycle is in progress |
| enum_wake_cap | input | 1 | Wake capability negotiated at enumeration |
| wake_effective | output | 1 | Wake enable that applies now |

## Verification
Tokens are sent with every combination of ACK and no-ACK against link state 1 and several reserved codes. This separates the capture path, the silent no-ACK case and the reject path. The same tokens are repeated in host mode to show the mode gate. Software writes are tried with protection on and off, alone and on the same cycle as a capture, which shows the write path and its priority. The resume window is timed with duration codes 0 and 15 under continuous ticks, and with a mid-range code under sparse ticks. Together these show that the length is counted in ticks, not clocks, and that the scale factor is right.

// File: rtl/lpm_attr_pkg.sv
`timescale 1ns/1ps
package lpm_attr_pkg;
  localparam int EP_W     = 4;
  localparam int HIRD_W   = 4;
  localparam int LS_W     = 4;
  localparam int WORD_W   = 16;
  localparam int EP_LSB   = 12;
  localparam int RW_BIT   = 8;
  localparam int HIRD_LSB = 4;
  localparam int LS_LSB   = 0;
  localparam logic [LS_W-1:0] LS_SLEEP = LS_W'(1);

  typedef struct packed {
    logic [EP_W-1:0]   ep;
    logic              rmtwak;
    logic [HIRD_W-1:0] hird;
    logic [LS_W-1:0]   ls;
  } lpm_attr_t;

  function automatic logic [WORD_W-1:0] attr_pack(lpm_attr_t a);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EP_LSB +: EP_W]     = a.ep;
    w[RW_BIT]             = a.rmtwak;
    w[HIRD_LSB +: HIRD_W] = a.hird;
    w[LS_LSB +: LS_W]     = a.ls;
    return w;
  endfunction

  function automatic lpm_attr_t attr_unpack(logic [WORD_W-1:0] w);
    lpm_attr_t a;
    a.ep     = w[EP_LSB +: EP_W];
    a.rmtwak = w[RW_BIT];
    a.hird   = w[HIRD_LSB +: HIRD_W];
    a.ls     = w[LS_LSB +: LS_W];
    return a;
  endfunction
endpackage

// File: rtl/lpm_link_check.sv
`timescale 1ns/1ps
module lpm_link_check
  import lpm_attr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            host_mode,
  input  logic            tok_valid,
  input  logic            tok_ack,
  input  logic [LS_W-1:0] tok_lnkstate,
  output logic            capture_en,
  output logic            accept_q,
  output logic            reject_q
);
  logic dev_tok;
  logic ls_ok;

  assign dev_tok    = tok_valid & ~host_mode;
  assign ls_ok      = (tok_lnkstate == LS_SLEEP);
  assign capture_en = dev_tok & tok_ack & ls_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      accept_q <= capture_en;
      reject_q <= dev_tok & ~ls_ok;
    end
  end
endmodule

// File: rtl/lpm_attr_reg.sv
`timescale 1ns/1ps
module lpm_attr_reg
  import lpm_attr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic              capture_en,
  input  lpm_attr_t         capture_val,
  input  logic              suspend_end,
  output lpm_attr_t         attr_q
);
  lpm_attr_t attr_d;

  always_comb begin
    attr_d = attr_q;
    if (capture_en) begin
      attr_d = capture_val;
    end else begin
      if (sw_we) attr_d = attr_unpack(sw_wdata);
      if (suspend_end) attr_d.rmtwak = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) attr_q <= '0;
    else     attr_q <= attr_d;
  end
endmodule

// File: rtl/lpm_resume_timer.sv
`timescale 1ns/1ps
module lpm_resume_timer #(
  parameter int CODE_W  = 4,
  parameter int BASE_US = 50,
  parameter int STEP_US = 75
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              drive,
  output logic              done
);
  localparam int MAX_LOAD = BASE_US + STEP_US * ((1 << CODE_W) - 1);
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(BASE_US) + CNT_W'(STEP_US) * CNT_W'(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      drive <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt   <= load_val;
        drive <= 1'b1;
      end else if (drive && tick) begin
        if (cnt == CNT_W'(1)) begin
          cnt   <= '0;
          drive <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lpm_wake_sel.sv
`timescale 1ns/1ps
module lpm_wake_sel (
  input  logic clk,
  input  logic rst,
  input  logic suspend_active,
  input  logic captured_wake,
  input  logic enum_wake_cap,
  output logic suspend_end,
  output logic wake_q
);
  logic susp_prev;

  assign suspend_end = susp_prev & ~suspend_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      susp_prev <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      susp_prev <= suspend_active;
      wake_q    <= suspend_active ? captured_wake : enum_wake_cap;
    end
  end
endmodule

// File: rtl/lpm_attr_unit.sv
`timescale 1ns/1ps
module lpm_attr_unit
  import lpm_attr_pkg::*;
#(
  parameter int RESUME_BASE_US = 50,
  parameter int RESUME_STEP_US = 75
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_mode,
  input  logic              write_protect,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wr_data,
  output logic [WORD_W-1:0] reg_rd_data,
  input  logic              tok_valid,
  input  logic              tok_ack,
  input  logic [EP_W-1:0]   tok_endpoint,
  input  logic              tok_rmtwak,
  input  logic [HIRD_W-1:0] tok_hird,
  input  logic [LS_W-1:0]   tok_lnkstate,
  output logic              lpm_accept,
  output logic              lpm_reject,
  input  logic              us_tick,
  input  logic              start_resume,
  output logic              resume_drive,
  output logic              resume_done,
  input  logic              suspend_active,
  input  logic              enum_wake_cap,
  output logic              wake_effective
);
  logic      capture_en;
  logic      suspend_end;
  lpm_attr_t attr_q;
  lpm_attr_t tok_fields;

  assign tok_fields.ep     = tok_endpoint;
  assign tok_fields.rmtwak = tok_rmtwak;
  assign tok_fields.hird   = tok_hird;
  assign tok_fields.ls     = tok_lnkstate;

  lpm_link_check u_check (
    .clk          (clk),
    .rst          (rst),
    .host_mode    (host_mode),
    .tok_valid    (tok_valid),
    .tok_ack      (tok_ack),
    .tok_lnkstate (tok_lnkstate),
    .capture_en   (capture_en),
    .accept_q     (lpm_accept),
    .reject_q     (lpm_reject)
  );

  lpm_attr_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .sw_we       (reg_wr_en & ~write_protect),
    .sw_wdata    (reg_wr_data),
    .capture_en  (capture_en),
    .capture_val (tok_fields),
    .suspend_end (suspend_end),
    .attr_q      (attr_q)
  );

  lpm_resume_timer #(
    .CODE_W  (HIRD_W),
    .BASE_US (RESUME_BASE_US),
    .STEP_US (RESUME_STEP_US)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start_resume),
    .tick  (us_tick),
    .code  (attr_q.hird),
    .drive (resume_drive),
    .done  (resume_done)
  );

  lpm_wake_sel u_wake (
    .clk            (clk),
    .rst            (rst),
    .suspend_active (suspend_active),
    .captured_wake  (attr_q.rmtwak),
    .enum_wake_cap  (enum_wake_cap),
    .suspend_end    (suspend_end),
    .wake_q         (wake_effective)
  );

  assign reg_rd_data = attr_pack(attr_q);
endmodule

// File: rtl/lpm_attr_chk.sv
`timescale 1ns/1ps
module lpm_attr_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_mode,
  input logic        write_protect,
  input logic        reg_wr_en,
  input logic        tok_valid,
  input logic        tok_ack,
  input logic [3:0]  tok_lnkstate,
  input logic        suspend_active,
  input logic [15:0] reg_rd_data,
  input logic        lpm_accept,
  input logic        lpm_reject,
  input logic        resume_drive,
  input logic        resume_done
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[11:9] == 3'b000);

  // R3
  protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (write_protect && !tok_valid && suspend_active) |=> $stable(reg_rd_data));

  // R4
  accept_cause_chk: assert property (@(posedge clk) disable iff (rst)
    lpm_accept |-> $past(tok_valid && tok_ack && !host_mode && tok_lnkstate == 4'd1));

  // R4
  accept_word_chk: assert property (@(posedge clk) disable iff (rst)
    lpm_accept |-> reg_rd_data[3:0] == 4'd1);

  // R6
  excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(lpm_accept && lpm_reject));

  // R7
  host_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (host_mode && suspend_active && !(reg_wr_en && !write_protect)) |=> $stable(reg_rd_data));

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    resume_done |-> (!resume_drive && $past(resume_drive)));

  // R11
  wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(suspend_active) && !tok_valid) |=> !reg_rd_data[8]);
endmodule

bind lpm_attr_unit lpm_attr_chk i_chk (
  .clk            (clk),
  .rst            (rst),
  .host_mode      (host_mode),
  .write_protect  (write_protect),
  .reg_wr_en      (reg_wr_en),
  .tok_valid      (tok_valid),
  .tok_ack        (tok_ack),
  .tok_lnkstate   (tok_lnkstate),
  .suspend_active (suspend_active),
  .reg_rd_data    (reg_rd_data),
  .lpm_accept     (lpm_accept),
  .lpm_reject     (lpm_reject),
  .resume_drive   (resume_drive),
  .resume_done    (resume_done)
);

// File: tb/test_lpm_attr_unit.sv
`timescale 1ns/1ps
module test_lpm_attr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_mode = 1'b0, write_protect = 1'b0, reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic        tok_valid = 1'b0, tok_ack = 1'b0, tok_rmtwak = 1'b0;
  logic [3:0]  tok_endpoint = '0, tok_hird = '0, tok_lnkstate = '0;
  logic        lpm_accept, lpm_reject;
  logic        us_tick = 1'b0, start_resume = 1'b0;
  logic        resume_drive, resume_done;
  logic        suspend_active = 1'b0, enum_wake_cap = 1'b0;
  logic        wake_effective;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lpm_attr_unit i_lpm_attr_unit (
    .clk(clk), .rst(rst), .host_mode(host_mode), .write_protect(write_protect),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .tok_valid(tok_valid), .tok_ack(tok_ack), .tok_endpoint(tok_endpoint),
    .tok_rmtwak(tok_rmtwak), .tok_hird(tok_hird), .tok_lnkstate(tok_lnkstate),
    .lpm_accept(lpm_accept), .lpm_reject(lpm_reject), .us_tick(us_tick),
    .start_resume(start_resume), .resume_drive(resume_drive), .resume_done(resume_done),
    .suspend_active(suspend_active), .enum_wake_cap(enum_wake_cap),
    .wake_effective(wake_effective)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic sw_write(logic [15:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic send_tok(logic ack, logic [3:0] ep, logic rw, logic [3:0] hird, logic [3:0] ls);
    tok_valid = 1'b1; tok_ack = ack; tok_endpoint = ep;
    tok_rmtwak = rw; tok_hird = hird; tok_lnkstate = ls;
    @(negedge clk);
    tok_valid = 1'b0; tok_ack = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 word", reg_rd_data, 16'h0000);
    chk("R1 pulses", {lpm_accept, lpm_reject, resume_drive, resume_done, wake_effective}, 5'b0);
  endtask

  task automatic t_sw_write;
    sw_write(16'hFFFF);
    chk("R2 reserved bits masked", reg_rd_data, 16'hF1FF);
    sw_write(16'h5123);
    chk("R3 write lands", reg_rd_data, 16'h5123);
    write_protect = 1'b1;
    sw_write(16'hA0F0);
    chk("R3 protected write ignored", reg_rd_data, 16'h5123);
    write_protect = 1'b0;
  endtask

  task automatic t_capture;
    send_tok(1'b1, 4'h9, 1'b1, 4'h6, 4'h1);
    chk("R4 captured word", reg_rd_data, 16'h9161);
    chk("R4 accept high", lpm_accept, 1'b1);
    chk("R6 no reject on L1", lpm_reject, 1'b0);
    @(negedge clk);
    chk("R4 accept one cycle", lpm_accept, 1'b0);
    send_tok(1'b0, 4'h3, 1'b0, 4'h2, 4'h1);
    chk("R5 no-ACK word kept", reg_rd_data, 16'h9161);
    chk("R5 no pulses", {lpm_accept, lpm_reject}, 2'b00);
  endtask

  task automatic t_reject;
    logic [3:0] codes [3] = '{4'h0, 4'h2, 4'hF};
    foreach (codes[i]) begin
      send_tok(i[0], 4'h4, 1'b0, 4'h1, codes[i]);
      chk("R6 reserved word kept", reg_rd_data, 16'h9161);
      chk("R6 reject pulse", {lpm_accept, lpm_reject}, 2'b01);
      @(negedge clk);
      chk("R6 reject one cycle", lpm_reject, 1'b0);
    end
  endtask

  task automatic t_host;
    host_mode = 1'b1;
    sw_write(16'h2034);
    send_tok(1'b1, 4'hE, 1'b1, 4'h7, 4'h1);
    chk("R7 host word kept", reg_rd_data, 16'h2034);
    chk("R7 host no pulses", {lpm_accept, lpm_reject}, 2'b00);
    send_tok(1'b1, 4'hE, 1'b1, 4'h7, 4'h5);
    chk("R7 host no reject", lpm_reject, 1'b0);
    host_mode = 1'b0;
  endtask

  task automatic t_priority;
    reg_wr_en = 1'b1; reg_wr_data = 16'h7777;
    send_tok(1'b1, 4'hC, 1'b0, 4'h3, 4'h1);
    reg_wr_en = 1'b0;
    chk("R8 capture beats write", reg_rd_data, 16'hC031);
  endtask

  task automatic run_resume(logic [3:0] code, int gap, string tag);
    int ticks = 0;
    int guard = 0;
    int k = 0;
    sw_write({8'h00, code, 4'h1});
    start_resume = 1'b1; us_tick = 1'b1;
    @(negedge clk);
    start_resume = 1'b0;
    chk({tag, " drive up"}, resume_drive, 1'b1);
    while (resume_drive && guard < 20000) begin
      us_tick = (k % gap) == 0;
      if (us_tick) ticks++;
      k++; guard++;
      @(negedge clk);
    end
    us_tick = 1'b0;
    chk({tag, " tick count"}, ticks, 50 + 75 * code);
    chk({tag, " done pulse"}, resume_done, 1'b1);
    @(negedge clk);
    chk({tag, " done one cycle"}, {resume_done, resume_drive}, 2'b00);
  endtask

  task automatic t_wake;
    send_tok(1'b1, 4'h1, 1'b1, 4'h0, 4'h1);
    suspend_active = 1'b1; enum_wake_cap = 1'b0;
    @(negedge clk);
    chk("R10 captured wake in suspend", wake_effective, 1'b1);
    suspend_active = 1'b0;
    @(negedge clk);
    chk("R10 enum wake after suspend", wake_effective, 1'b0);
    chk("R11 wake bit cleared", reg_rd_data[8], 1'b0);
    enum_wake_cap = 1'b1;
    @(negedge clk);
    chk("R10 follows enum cap", wake_effective, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sw_write();
    t_capture();
    t_reject();
    t_host();
    t_priority();
    run_resume(4'd0, 1, "R9 code0");
    run_resume(4'd15, 1, "R9 code15");
    run_resume(4'd4, 3, "R9 sparse");
    t_wake();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule